// File: doc/BRIEF.md
# Barrel Shifter with Carry Capture

The block is a single-operation 32-bit barrel shifter for an integer datapath. It shifts left logically, right logically or right arithmetically. Each result comes with its own condition flags: zero, sign, carry and overflow. Carry holds the last bit pushed out past the end of the word. Overflow is always cleared.

The shift distance is selected by one input. It is either a small immediate, zero-extended, or the low bits of a register value. All bits of the register above those low bits are ignored. The result and flags are computed in one combinational pass and then held in an output register, so they appear one clock after the inputs are presented.

Top module: `shf_unit`

## Requirements
- R1: With op_i = 2'b00 or 2'b10, result_o is operand_i shifted left by the amount, filling with zeros.
- R2: With op_i = 2'b01, result_o is operand_i shifted right by the amount, filling with zeros.
- R3: With op_i = 2'b11, result_o is operand_i shifted right by the amount, filling every vacated bit with operand_i[31].
- R4: With use_imm_i = 1 the amount is imm_i (0 to 31), zero-extended, and rs_i is ignored. With use_imm_i = 0 the amount is rs_i[4:0], and rs_i[31:5] and imm_i are ignored.
- R5: For a right shift by a nonzero amount n, flag_cy_o equals operand_i[n-1].
- R6: For a left shift by a nonzero amount n, flag_cy_o equals operand_i[32-n].
- R7: An amount of zero returns operand_i unchanged for every op_i value and clears flag_cy_o.
- R8: flag_z_o is 1 exactly when result_o is zero, and flag_s_o equals result_o[31].
- R9: flag_ov_o is 0 after every shift.
- R10: Outputs update on the rising clk_i edge that follows the inputs. While rst_ni is low (asynchronous, active low), result_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Shift kind: bit 0 = right, both bits set = arithmetic |
| use_imm_i | input | 1 | Take the amount from imm_i instead of rs_i |
| imm_i | input | 5 | Immediate shift amount |
| rs_i | input | 32 | Register value whose low 5 bits give the amount |
| operand_i | input | 32 | Value to shift |
| result_o | output | 32 | Registered shift result |
| flag_z_o | output | 1 | Result is zero |
| flag_s_o | output | 1 | Result sign bit |
| flag_cy_o | output | 1 | Last bit shifted out |
| flag_ov_o | output | 1 | Overflow, always 0 |

## Verification
The carry bit is the hardest to check. At the extreme amounts it comes from the far end of the operand (bit 0 for a right shift by 1, bit 31 for a left shift by 1), and at amount zero it must read as clear. To reach these cases, the stimulus sweeps every amount from 0 to 31 against operands with isolated bits at both ends and alternating patterns. Each sweep is run twice, once with the amount taken from the immediate and once from the register. During each run the unused amount source carries a conflicting value, and in the register run the upper register bits are filled with noise.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL     = 2'b00,
    SHF_LSR     = 2'b01,
    SHF_LSL_ALT = 2'b10,
    SHF_ASR     = 2'b11
  } shf_op_e;

  function automatic logic op_is_right(logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_arith(logic [1:0] op);
    return op[0] & op[1];
  endfunction
endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic             use_imm_i,
  input  logic [AMT_W-1:0] imm_i,
  input  logic [W-1:0]     rs_i,
  output logic [AMT_W-1:0] amt_o
);
  always_comb amt_o = use_imm_i ? imm_i : rs_i[AMT_W-1:0];
endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     operand_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             right_i,
  input  logic             arith_i,
  output logic [W-1:0]     result_o,
  output logic             cy_o
);
  localparam int EW = W + 1;

  // one guard slot catches the last bit shifted out
  logic [EW-1:0] stg [0:AMT_W];
  logic          fill;

  always_comb begin
    fill   = arith_i & operand_i[W-1];
    stg[0] = right_i ? {operand_i, 1'b0} : {1'b0, operand_i};
  end

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int D = 1 << k;
    always_comb begin
      if (!amt_i[k])     stg[k+1] = stg[k];
      else if (right_i)  stg[k+1] = {{D{fill}}, stg[k][EW-1:D]};
      else               stg[k+1] = {stg[k][EW-1-D:0], {D{1'b0}}};
    end
  end

  always_comb begin
    if (right_i) begin
      result_o = stg[AMT_W][EW-1:1];
      cy_o     = stg[AMT_W][0];
    end else begin
      result_o = stg[AMT_W][W-1:0];
      cy_o     = stg[AMT_W][W];
    end
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] result_i,
  output logic         z_o,
  output logic         s_o
);
  always_comb begin
    z_o = ~|result_i;
    s_o = result_i[W-1];
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  input  logic             use_imm_i,
  input  logic [AMT_W-1:0] imm_i,
  input  logic [WIDTH-1:0] rs_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o,
  output logic             flag_z_o,
  output logic             flag_s_o,
  output logic             flag_cy_o,
  output logic             flag_ov_o
);
  import shf_pkg::*;

  logic [AMT_W-1:0] amt;
  logic [WIDTH-1:0] res_d;
  logic             cy_d, z_d, s_d;
  logic             past_ok;

  shf_amount_sel #(.W(WIDTH), .AMT_W(AMT_W)) u_sel (
    .use_imm_i(use_imm_i), .imm_i(imm_i), .rs_i(rs_i), .amt_o(amt)
  );

  shf_core #(.W(WIDTH), .AMT_W(AMT_W)) u_core (
    .operand_i(operand_i), .amt_i(amt),
    .right_i(op_is_right(op_i)), .arith_i(op_is_arith(op_i)),
    .result_o(res_d), .cy_o(cy_d)
  );

  shf_flags #(.W(WIDTH)) u_flags (.result_i(res_d), .z_o(z_d), .s_o(s_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      flag_z_o  <= 1'b0;
      flag_s_o  <= 1'b0;
      flag_cy_o <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      result_o  <= res_d;
      flag_z_o  <= z_d;
      flag_s_o  <= s_d;
      flag_cy_o <= cy_d;
      past_ok   <= 1'b1;
    end
  end

  assign flag_ov_o = 1'b0;

  assert_zero_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (flag_z_o == (result_o == '0)));

  assert_sign_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (flag_s_o == result_o[WIDTH-1]));

  assert_zero_amt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && amt == '0) |=> (result_o == $past(operand_i) && !flag_cy_o));

  assert_sign_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && op_i == SHF_ASR && operand_i[WIDTH-1]) |=> result_o[WIDTH-1]);

  assert_zero_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && op_i == SHF_LSR && amt != '0) |=> !result_o[WIDTH-1]);
endmodule

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  op = 0;
  logic        use_imm = 0;
  logic [4:0]  imm = 0;
  logic [31:0] rs = 0, opnd = 0;
  logic [31:0] res;
  logic        fz, fs, fcy, fov;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  shf_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .use_imm_i(use_imm), .imm_i(imm),
    .rs_i(rs), .operand_i(opnd), .result_o(res), .flag_z_o(fz),
    .flag_s_o(fs), .flag_cy_o(fcy), .flag_ov_o(fov)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op=%0d amt_src=%0d opnd=%h)",
               tag, act, exp, op, use_imm, opnd);
    end
  endtask

  task automatic step(logic [1:0] o, bit src_imm, int n, logic [31:0] a);
    logic [31:0] er;
    logic        ecy;
    string       rtag, ctag;
    op = o; opnd = a; use_imm = src_imm;
    if (src_imm) begin
      imm = 5'(n);
      rs  = 32'hDEAD_BEE0 | 32'(5'(~n));   // conflicting amount, R4
    end else begin
      rs  = {27'h4B3_C5A1, 5'(n)};         // upper bits noise, R4
      imm = 5'(~n);
    end
    if (o[0] == 1'b0) begin
      er = a << n; ecy = (n == 0) ? 1'b0 : a[32-n]; rtag = "R1"; ctag = "R6";
    end else if (o[1]) begin
      er = 32'($signed(a) >>> n); ecy = (n == 0) ? 1'b0 : a[n-1];
      rtag = "R3"; ctag = "R5";
    end else begin
      er = a >> n; ecy = (n == 0) ? 1'b0 : a[n-1]; rtag = "R2"; ctag = "R5";
    end
    if (!src_imm) rtag = "R4";
    if (n == 0) begin rtag = "R7"; ctag = "R7"; end
    @(negedge clk);
    chk(rtag, res, er);
    chk(ctag, 32'(fcy), 32'(ecy));
    chk("R8", 32'(fz), 32'(er == 0));
    chk("R8", 32'(fs), 32'(er[31]));
    chk("R9", 32'(fov), 32'd0);
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0000;
    pats[3] = 32'h1234_5678; pats[4] = 32'h7FFF_FFFE; pats[5] = 32'hA5C3_0F96;
    opnd = 32'hFFFF_FFFF; use_imm = 1; imm = 5'd3;
    repeat (3) @(negedge clk);
    chk("R10", res, 32'd0);
    chk("R10", {28'd0, fz, fs, fcy, fov}, 32'd0);
    rst_n = 1;
    // latency: inputs set after an edge show only after the next edge
    op = 2'b01; opnd = 32'h0000_0100; use_imm = 1; imm = 5'd4;
    @(negedge clk);
    chk("R10", res, 32'h0000_0010);
    opnd = 32'h0000_0800; #2;
    chk("R10", res, 32'h0000_0010);
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
          for (int n = 0; n < 32; n++)
            step(2'(o), s[0], n, pats[p]);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule